// File: doc/BRIEF.md
# Radix-16 Sequential Shift-Add Multiplier

This block multiplies two unsigned integers of a parameterised width, either 16 or 32 bits. It reads the multiplier four bits at a time, starting with the least significant hex digit. In each step it forms the multiplicand times that digit, then adds the result into a double-width accumulator at the correct weight. The digit product uses no multiplier array. A 16-way selection picks one combination of shifted copies of the multiplicand, joined by at most two adds or subtracts.

A request is one cycle of `start` with the operands applied while the block is idle. `busy` then stays high for a fixed number of cycles, one for each hex digit of the multiplier. After that, `done` pulses for one cycle and `product` holds the full double-width result. The result stays on `product` until the next request is accepted. The latency never depends on the operand values.

Top module: `hexmul_top`

## Requirements
- R1: While reset is asserted and after its release, `busy` is 0, `done` is 0 and `product` is 0 until a request is accepted.
- R2: A request is accepted on a rising clock edge where `start` is 1 and `busy` is 0. The operands on `multiplicand` and `multiplier` at that edge are captured, and `busy` becomes 1 after that edge.
- R3: Once raised, `busy` stays high for exactly WIDTH/4 clock cycles: 4 cycles when WIDTH is 16 and 8 cycles when WIDTH is 32.
- R4: `done` is 1 for exactly one cycle. That cycle directly follows the last cycle with `busy` high.
- R5: When `done` is 1, `product` equals the exact unsigned 2×WIDTH-bit product of the captured operands.
- R6: In every step, the partial product equals the multiplicand times the current 4-bit digit exactly, for all 16 digit values. Examples are 15×M = (M<<4) − M and 10×M = (M<<3) + (M<<1).
- R7: A `start` pulse while `busy` is 1 is ignored. It changes neither the result nor the timing of the operation in progress, and it produces no extra `done`.
- R8: After `done`, `product` keeps its value until the next request is accepted.
- R9: A zero multiplicand or a zero multiplier still takes the full WIDTH/4 cycles and gives a product of 0.
- R10: Multiplier digits are consumed least significant first. Digit k (bits 4k+3..4k) is weighted by 16^k, so a multiplier with a single nonzero digit d at position k gives multiplicand × d × 16^k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request strobe, taken only while idle |
| multiplicand | input | WIDTH | Unsigned multiplicand |
| multiplier | input | WIDTH | Unsigned multiplier, read one hex digit per step |
| busy | output | 1 | High while the steps are running |
| done | output | 1 | One-cycle pulse when the product is complete |
| product | output | 2*WIDTH | Unsigned product, held until the next request |

## Verification
Two of the patterns each isolate one part of the datapath:
- A multiplier with one nonzero hex digit, swept over every digit value and every position, tests each of the 16 shift-add cases separately (R6). It also tests the weighting, so a step that adds at the wrong weight or reads the wrong digit shows up directly (R10).
- All-ones times all-ones drives the largest sums into the accumulator. It exposes a partial-product width or carry that is too narrow.

Further patterns cover the remaining behaviour:
- Zero operands confirm that latency does not depend on the data (R9).
- Random operands cover mixed digit combinations.
- Extra `start` pulses during `busy` check that a request in flight cannot be disturbed (R7).

// File: rtl/hexmul_pkg.sv
package hexmul_pkg;
  localparam int DIGIT_BITS = 4;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic load;  // capture operands, clear accumulator
    logic step;  // consume one hex digit
  } hexmul_ctl_t;
endpackage

// File: rtl/hexmul_digit_pp.sv
module hexmul_digit_pp
  import hexmul_pkg::*;
#(
  parameter int WIDTH = 16,
  localparam int PW = WIDTH + DIGIT_BITS
) (
  input  logic [WIDTH-1:0]      mcand,
  input  logic [DIGIT_BITS-1:0] digit,
  output logic [PW-1:0]         partial
);
  logic [PW-1:0] m1, m2, m4, m8, m16;

  assign m1  = PW'(mcand);
  assign m2  = m1 << 1;
  assign m4  = m1 << 2;
  assign m8  = m1 << 3;
  assign m16 = m1 << 4;

  // shift-and-add selection, at most two adders per case
  always_comb begin
    unique case (digit)
      4'd0:  partial = '0;
      4'd1:  partial = m1;
      4'd2:  partial = m2;
      4'd3:  partial = m2 + m1;
      4'd4:  partial = m4;
      4'd5:  partial = m4 + m1;
      4'd6:  partial = m4 + m2;
      4'd7:  partial = m8 - m1;
      4'd8:  partial = m8;
      4'd9:  partial = m8 + m1;
      4'd10: partial = m8 + m2;
      4'd11: partial = m8 + m2 + m1;
      4'd12: partial = m8 + m4;
      4'd13: partial = m8 + m4 + m1;
      4'd14: partial = m16 - m2;
      default: partial = m16 - m1;
    endcase
  end
endmodule

// File: rtl/hexmul_ctrl.sv
module hexmul_ctrl
  import hexmul_pkg::*;
#(
  parameter int WIDTH = 16,
  localparam int STEPS = WIDTH / DIGIT_BITS,
  localparam int CW = $clog2(STEPS + 1)
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  output logic        busy,
  output logic        done,
  output hexmul_ctl_t ctl
);
  logic [CW-1:0] stepCnt;

  assign ctl.load = start && !busy;
  assign ctl.step = busy;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      stepCnt <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy    <= 1'b1;
          stepCnt <= '0;
        end
      end else begin
        stepCnt <= stepCnt + 1'b1;
        if (stepCnt == CW'(STEPS - 1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  // independent run-length counter used only by the checks below
  logic [CW:0] runLen;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) runLen <= '0;
    else if (busy) runLen <= runLen + 1'b1;
    else runLen <= '0;
  end

  a_r2_accept_needs_start: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(start));
  a_r3_busy_length: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> runLen == (CW+1)'(STEPS));
  a_r4_done_follows_busy: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> done);
  a_r4_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  a_r4_done_not_busy: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);
endmodule

// File: rtl/hexmul_datapath.sv
module hexmul_datapath
  import hexmul_pkg::*;
#(
  parameter int WIDTH = 16,
  localparam int PW = WIDTH + DIGIT_BITS,
  localparam int AW = 2 * WIDTH
) (
  input  logic             clk,
  input  logic             rstN,
  input  hexmul_ctl_t      ctl,
  input  logic             doneIn,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  output logic [AW-1:0]    acc
);
  logic [WIDTH-1:0] mcandReg;
  logic [WIDTH-1:0] mplierReg;
  logic [PW-1:0]    partial;
  logic [PW-1:0]    upperSum;

  hexmul_digit_pp #(.WIDTH(WIDTH)) u_pp (
    .mcand   (mcandReg),
    .digit   (mplierReg[DIGIT_BITS-1:0]),
    .partial (partial)
  );

  // upper half plus partial cannot exceed 16*(2^W-1), fits in PW bits
  assign upperSum = PW'(acc[AW-1:WIDTH]) + partial;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mcandReg  <= '0;
      mplierReg <= '0;
      acc       <= '0;
    end else if (ctl.load) begin
      mcandReg  <= opA;
      mplierReg <= opB;
      acc       <= '0;
    end else if (ctl.step) begin
      mplierReg <= mplierReg >> DIGIT_BITS;
      acc       <= {upperSum, acc[WIDTH-1:DIGIT_BITS]};
    end
  end

  a_r6_partial_exact: assert property (@(posedge clk) disable iff (!rstN)
    ctl.step |-> partial == PW'(mcandReg) * PW'(mplierReg[DIGIT_BITS-1:0]));
  a_r10_digits_consumed: assert property (@(posedge clk) disable iff (!rstN)
    doneIn |-> mplierReg == '0);
endmodule

// File: rtl/hexmul_top.sv
module hexmul_top
  import hexmul_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic [WIDTH-1:0]   multiplicand,
  input  logic [WIDTH-1:0]   multiplier,
  output logic               busy,
  output logic               done,
  output logic [2*WIDTH-1:0] product
);
  hexmul_ctl_t ctl;

  hexmul_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .start (start),
    .busy  (busy),
    .done  (done),
    .ctl   (ctl)
  );

  hexmul_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .ctl    (ctl),
    .doneIn (done),
    .opA    (multiplicand),
    .opB    (multiplier),
    .acc    (product)
  );

  a_r8_product_held: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !start) |=> $stable(product));
  a_r7_no_load_while_busy: assert property (@(posedge clk) disable iff (!rstN)
    (busy && start) |=> busy || done);
endmodule

// File: tb/hexmul_top_tb.sv
`timescale 1ns/1ps
module hexmul_top_tb;
  localparam int W = 16;
  localparam int STEPS = W / 4;
  localparam int PW = 2 * W;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [W-1:0] multiplicand = '0;
  logic [W-1:0] multiplier = '0;
  logic busy, done;
  logic [PW-1:0] product;

  int checks = 0;
  int errors = 0;
  logic [PW-1:0] expQ[$];
  logic [PW-1:0] lastExp = '0;
  int busyRun = 0;
  logic prevDone = 1'b0;
  int doneCount = 0;
  int pushCount = 0;

  always #4 clk = ~clk;

  hexmul_top #(.WIDTH(W)) u_dut (
    .clk(clk), .rstN(rstN), .start(start),
    .multiplicand(multiplicand), .multiplier(multiplier),
    .busy(busy), .done(done), .product(product)
  );

  task automatic check(input logic ok, input string req,
                       input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // driver: issues one request, optionally pokes start while busy (R7)
  task automatic doOp(input logic [W-1:0] a, input logic [W-1:0] b,
                      input bit poke);
    @(negedge clk);
    while (busy) @(negedge clk);
    start = 1'b1;
    multiplicand = a;
    multiplier = b;
    expQ.push_back(PW'(a) * PW'(b));
    pushCount++;
    @(negedge clk);
    if (poke) begin
      multiplicand = ~a;
      multiplier = b + 16'h1234;
      @(negedge clk);
    end
    start = 1'b0;
    multiplicand = $urandom();
    multiplier = $urandom();
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rstN) begin
      if (busy) busyRun++;
      if (done) begin
        doneCount++;
        check(!prevDone, "R4 done pulse width", 64'(prevDone), 64'd0);
        check(busyRun == STEPS, "R3/R9 busy length", 64'(busyRun), 64'(STEPS));
        if (expQ.size() == 0) begin
          check(1'b0, "R7 unexpected result", 64'(product), 64'd0);
        end else begin
          lastExp = expQ.pop_front();
          check(product == lastExp, "R5/R6/R10 product", 64'(product), 64'(lastExp));
        end
        busyRun = 0;
      end
      prevDone = done;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(busy == 1'b0 && done == 1'b0, "R1 flags in reset", {62'd0, busy, done}, 64'd0);
    check(product == '0, "R1 product in reset", 64'(product), 64'd0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check(busy == 1'b0 && product == '0, "R1 idle after reset", 64'(product), 64'd0);

    // R2: accepted start raises busy on the following cycle
    @(negedge clk);
    start = 1'b1; multiplicand = 16'd3; multiplier = 16'd5;
    expQ.push_back(32'd15); pushCount++;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R2 busy after accept", 64'(busy), 64'd1);

    // R9: zero operands
    doOp(16'h0000, 16'hFFFF, 1'b0);
    doOp(16'hFFFF, 16'h0000, 1'b0);
    doOp(16'h0000, 16'h0000, 1'b0);
    // all ones squared
    doOp(16'hFFFF, 16'hFFFF, 1'b0);
    // R6/R10: single hex digit at every position, every value
    for (int pos = 0; pos < STEPS; pos++)
      for (int d = 1; d < 16; d++)
        doOp(16'hFFFF, W'(d) << (4 * pos), 1'b0);
    for (int d = 1; d < 16; d++)
      doOp(W'(d), 16'hBEEF, 1'b0);
    // R7: start poked while busy
    for (int i = 0; i < 6; i++)
      doOp(W'($urandom()), W'($urandom()), 1'b1);
    // random operands
    for (int i = 0; i < 150; i++)
      doOp(W'($urandom()), W'($urandom()), 1'b0);

    @(negedge clk);
    while (busy) @(negedge clk);
    repeat (6) @(negedge clk);
    // R8: product held after done
    check(product == lastExp, "R8 product held", 64'(product), 64'(lastExp));
    check(doneCount == pushCount, "R7 result count", 64'(doneCount), 64'(pushCount));
    check(expQ.size() == 0, "R5 scoreboard drained", 64'(expQ.size()), 64'd0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule